// File: doc/BRIEF.md
# Resettable Modulo-2 Token Counter

This block is a primitive for token-driven, delay-insensitive logic. Each discrete signal is a one-cycle pulse. Count tokens arrive on one input line and reset tokens on another. The block keeps a single parity bit that records whether one count token is waiting for its partner. A second count token completes the pair and emits a token on the pair output. A reset token that meets a half-filled pair clears it and emits a token on the acknowledge output.

No token is ever dropped. Tokens that cannot be served yet wait in a per-line pending counter, and each line's ready output tells the sender when that counter has no room left. A reset that finds the parity bit clear has nothing to cancel. It waits until count tokens have set the bit, and is then served. When both lines could be served in the same cycle, an internal arbiter decides the order and swaps priority after each such conflict, so neither line can starve.

Top module: `mod2_tok_ctr`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `pair_o` and `ack_o` are low and both ready outputs are high.
- R2: With no reset tokens present, every second count token served produces exactly one `pair_o` pulse and leaves the parity bit clear.
- R3: A reset token served while the parity bit is set produces one `ack_o` pulse and clears the bit, so two further count tokens are needed for the next `pair_o`.
- R4: A reset token that finds the parity bit clear produces no `ack_o`. It stays pending until a count token has set the bit, and is then served.
- R5: When a count token and a reset token are both servable in the same cycle, the first such conflict after reset goes to the count line, and priority then alternates on each later conflict.
- R6: Each input line holds up to QDEPTH pending tokens. Its ready output is low exactly when that many are held. A token is accepted only while ready is high.
- R7: At most one output pulse (`pair_o` or `ack_o`) is emitted per clock cycle, and at most one pending token is served per cycle.
- R8: A token accepted on a clock edge can be served at the following edge, at the earliest. Its output pulse is high during the cycle after that serving edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_tok_i | input | 1 | Count token pulse |
| cnt_rdy_o | output | 1 | Count line can accept a token |
| rst_tok_i | input | 1 | Reset token pulse |
| rst_rdy_o | output | 1 | Reset line can accept a token |
| pair_o | output | 1 | Pulse when a count pair completes |
| ack_o | output | 1 | Pulse acknowledging a reset that cleared a half pair |

## Verification
The bench builds the block with the default QDEPTH of 4. At that depth, four queued reset tokens held back by a clear parity bit fill the reset line, so the drop of ready and its recovery are reached in a directed test and also often in random traffic. Because the queues are this shallow, random bursts also create frequent same-cycle conflicts, which exercises the priority alternation many times over.

// File: rtl/mod2_tok_ctr_pkg.sv
package mod2_tok_ctr_pkg;
  typedef enum logic [1:0] {
    SRV_NONE = 2'd0,
    SRV_CNT  = 2'd1,
    SRV_RST  = 2'd2
  } srv_e;

  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_CNT  = 0;
  localparam int unsigned LINE_RST  = 1;
endpackage

// File: rtl/tok_pend_q.sv
module tok_pend_q #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic pop_i,
  output logic rdy_o,
  output logic nempty_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_acc;

  assign rdy_o    = (cnt_q < CW'(DEPTH));
  assign nempty_o = (cnt_q != '0);
  assign push_acc = push_i & rdy_o;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({push_acc, pop_i & nempty_o})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tok_alt_arb.sv
module tok_alt_arb
  import mod2_tok_ctr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_cnt_i,
  input  logic req_rst_i,
  output srv_e srv_o
);
  logic rst_first_q;
  logic conflict;

  assign conflict = req_cnt_i & req_rst_i;

  always_comb begin
    srv_o = SRV_NONE;
    if (conflict)       srv_o = rst_first_q ? SRV_RST : SRV_CNT;
    else if (req_cnt_i) srv_o = SRV_CNT;
    else if (req_rst_i) srv_o = SRV_RST;
  end

  // swap priority only when both lines competed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rst_first_q <= 1'b0;
    else if (conflict) rst_first_q <= ~rst_first_q;
  end
endmodule

// File: rtl/tok_par_core.sv
module tok_par_core
  import mod2_tok_ctr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  srv_e srv_i,
  output logic half_o,
  output logic pair_o,
  output logic ack_o
);
  logic half_q, pair_q, ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      pair_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      pair_q <= 1'b0;
      ack_q  <= 1'b0;
      unique case (srv_i)
        SRV_CNT: begin
          pair_q <= half_q;
          half_q <= ~half_q;
        end
        SRV_RST: begin
          ack_q  <= 1'b1;
          half_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign half_o = half_q;
  assign pair_o = pair_q;
  assign ack_o  = ack_q;
endmodule

// File: rtl/mod2_tok_ctr.sv
module mod2_tok_ctr
  import mod2_tok_ctr_pkg::*;
#(
  parameter int unsigned QDEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnt_tok_i,
  output logic cnt_rdy_o,
  input  logic rst_tok_i,
  output logic rst_rdy_o,
  output logic pair_o,
  output logic ack_o
);
  logic [NUM_LINES-1:0] tok_in, tok_pop, line_rdy, line_pend;
  logic half;
  srv_e srv;

  assign tok_in[LINE_CNT] = cnt_tok_i;
  assign tok_in[LINE_RST] = rst_tok_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    tok_pend_q #(.DEPTH(QDEPTH)) u_q (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (tok_in[g]),
      .pop_i    (tok_pop[g]),
      .rdy_o    (line_rdy[g]),
      .nempty_o (line_pend[g])
    );
  end

  // a reset only becomes servable once a half pair exists
  tok_alt_arb u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_cnt_i (line_pend[LINE_CNT]),
    .req_rst_i (line_pend[LINE_RST] & half),
    .srv_o     (srv)
  );

  assign tok_pop[LINE_CNT] = (srv == SRV_CNT);
  assign tok_pop[LINE_RST] = (srv == SRV_RST);

  tok_par_core u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srv_i  (srv),
    .half_o (half),
    .pair_o (pair_o),
    .ack_o  (ack_o)
  );

  assign cnt_rdy_o = line_rdy[LINE_CNT];
  assign rst_rdy_o = line_rdy[LINE_RST];
endmodule

// File: rtl/mod2_tok_ctr_chk.sv
module mod2_tok_ctr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cnt_tok_i,
  input logic cnt_rdy_o,
  input logic rst_tok_i,
  input logic rst_rdy_o,
  input logic pair_o,
  input logic ack_o,
  input logic half,
  input logic cnt_pend
);
  AST_ONE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pair_o, ack_o})); // R7
  AST_NO_OVERFLOW_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_tok_i |-> cnt_rdy_o); // R6
  AST_NO_OVERFLOW_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_tok_i |-> rst_rdy_o); // R6
  AST_RDY_FALL_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnt_rdy_o) |-> $past(cnt_tok_i)); // R6
  AST_RDY_FALL_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_rdy_o) |-> $past(rst_tok_i)); // R6
  AST_PAIR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o |-> !half); // R2
  AST_ACK_NEEDS_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(half) && !half)); // R3
  AST_RST_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half && !cnt_pend) |=> !ack_o); // R4
endmodule

bind mod2_tok_ctr mod2_tok_ctr_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_tok_i (cnt_tok_i),
  .cnt_rdy_o (cnt_rdy_o),
  .rst_tok_i (rst_tok_i),
  .rst_rdy_o (rst_rdy_o),
  .pair_o    (pair_o),
  .ack_o     (ack_o),
  .half      (half),
  .cnt_pend  (line_pend[0])
);

// File: tb/tb_mod2_tok_ctr.sv
`timescale 1ns/1ps
module tb_mod2_tok_ctr;
  localparam int unsigned QD = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cnt_tok_i = 1'b0, rst_tok_i = 1'b0;
  logic cnt_rdy_o, rst_rdy_o, pair_o, ack_o;

  int checks = 0, failures = 0;
  int qa = 0, qr = 0;
  bit m_half = 0, m_rfirst = 0, exp_pair = 0, exp_ack = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mod2_tok_ctr #(.QDEPTH(QD)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cnt_tok_i(cnt_tok_i), .cnt_rdy_o(cnt_rdy_o),
    .rst_tok_i(rst_tok_i), .rst_rdy_o(rst_rdy_o),
    .pair_o(pair_o), .ack_o(ack_o)
  );

  function automatic logic [3:0] expected();
    return {exp_pair, exp_ack, qa < QD, qr < QD};
  endfunction

  // reference step: one serving decision per cycle from the requirements
  function automatic void model_step(bit a, bit r);
    bit ea, er, wa, wr;
    ea = qa > 0;
    er = (qr > 0) && m_half;
    wr = er && (!ea || m_rfirst);
    wa = ea && !wr;
    if (ea && er) m_rfirst = !m_rfirst;
    exp_pair = wa && m_half;
    exp_ack  = wr;
    if (wa) m_half = !m_half;
    if (wr) m_half = 1'b0;
    qa = qa + (a ? 1 : 0) - (wa ? 1 : 0);
    qr = qr + (r ? 1 : 0) - (wr ? 1 : 0);
  endfunction

  task automatic check(string tag);
    logic [3:0] act, exp;
    act = {pair_o, ack_o, cnt_rdy_o, rst_rdy_o};
    exp = expected();
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s {pair,ack,cnt_rdy,rst_rdy} actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit a, bit r, string tag);
    bit ga, gr;
    @(negedge clk);
    check(tag);
    ga = a && (qa < QD);
    gr = r && (qr < QD);
    cnt_tok_i = ga;
    rst_tok_i = gr;
    model_step(ga, gr);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit seen_full;
    void'($urandom(32'h5eed_0c01));
    repeat (3) @(negedge clk);
    checks++;
    if ({pair_o, ack_o, cnt_rdy_o, rst_rdy_o} !== 4'b0011) begin
      failures++;
      $display("FAIL R1 in reset actual=%b expected=0011", {pair_o, ack_o, cnt_rdy_o, rst_rdy_o});
    end
    rst_ni = 1'b1;
    cyc(0, 0, "R1");

    // R2: two counts give one pair pulse, R8 latency checked per cycle
    cyc(1, 0, "R2"); idle(2, "R8"); cyc(1, 0, "R2"); idle(3, "R2");
    // R3: reset on a half pair acknowledges and clears
    cyc(1, 0, "R3"); idle(2, "R3"); cyc(0, 1, "R3"); idle(3, "R3");
    cyc(1, 0, "R3"); idle(3, "R3");
    cyc(1, 0, "R3"); idle(3, "R3");
    // R4: reset with clear parity waits for a count
    cyc(0, 1, "R4"); idle(4, "R4"); cyc(1, 0, "R4"); idle(4, "R4");
    // R5: conflicts alternate priority
    for (int n = 0; n < 4; n++) begin
      cyc(1, 0, "R5"); idle(2, "R5");
      cyc(1, 1, "R5"); idle(3, "R5");
      cyc(1, 0, "R5"); idle(3, "R5");
    end
    // R6: reset line fills while parity is clear
    seen_full = 0;
    for (int n = 0; n < QD + 2; n++) begin
      cyc(0, 1, "R6");
      if (qr == QD) seen_full = 1;
    end
    idle(2, "R6");
    checks++;
    if (!seen_full || rst_rdy_o !== 1'b0) begin
      failures++;
      $display("FAIL R6 rst_rdy_o actual=%b expected=0", rst_rdy_o);
    end
    for (int n = 0; n < 2 * QD + 2; n++) cyc(1, 0, "R6");
    idle(4, "R6");
    // R7: random traffic against the model
    for (int n = 0; n < 4000; n++)
      cyc(($urandom % 2) == 0, ($urandom % 3) == 0, "R7");
    for (int n = 0; n < 3 * QD; n++) cyc(1, 0, "R7");
    idle(6, "R7");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule